// File: doc/BRIEF.md
# Double-Buffered Serial Peripheral Controller

This block moves 8-bit words over a four-wire serial link, acting either as the clock-driving master or as a clocked slave. Software writes a byte into a one-deep holding buffer. The controller moves that byte into a separate shift register as soon as the shifter can take it, so the next byte can be queued while the current one is still on the wire. Each completed byte lands in a receive register, and a receive-full flag marks it until the register is read.

Software selects the role, the clock polarity and phase, the bit order and a clock divider, and sets them all while the enable bit is low. In master mode the serial clock comes from a divide-by-(N+1) clock enable. Queued bytes follow one another with no pause in the clock. In slave mode the external clock, select and data inputs are synchronised into the core clock domain. The busy flag has a different meaning in each role. For the master it shows that the shifter is active. For the slave it mirrors the select input. An interrupt request stays high while the block is enabled and the holding buffer is empty.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After reset the controller is disabled: tx_empty_o=1, busy_o=0, rx_full_o=0, irq_o=0, sclk_oe_o=0, sdo_oe_o=0 and sclk_o=0.
- R2: A control write always updates the enable bit. The role, polarity, phase, bit order and divider fields are taken only while the enable bit is 0, so a write made while enabled leaves them unchanged.
- R3: sclk_o idles at the polarity bit. The first edge after idle is the leading edge. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge. Each byte takes 8 clock periods (16 edges).
- R4: With the bit-order field at 0, bit 7 goes out first and the first received bit becomes bit 7. With the field at 1, bit 0 goes out first and the first received bit becomes bit 0.
- R5: A write to the holding buffer drives tx_empty_o to 0 on the next cycle, and any unsent byte in the buffer is overwritten. When the byte moves into the shifter, tx_empty_o returns to 1. If a write falls in the same cycle as a move, the newly written byte stays buffered.
- R6: In master mode, busy_o rises when a byte loads into the shifter and falls after the 8th trailing edge. If the buffer is full at that moment, the next byte loads in the same cycle, busy_o stays 1 and the clock keeps its normal half period.
- R7: In master mode, each half period of sclk_o lasts (div+1) core clock cycles.
- R8: After the 8th trailing edge, rx_data_o holds the received byte and rx_full_o is 1. A read pulse clears rx_full_o. If a read and a completion fall in the same cycle, rx_full_o stays 1.
- R9: In slave mode, busy_o equals the synchronised inverse of ss_ni, and sdo_oe_o is 1 only while the slave is selected. Deselecting the slave partway through a byte resets its bit count. A byte in the buffer moves into the shifter while the slave is deselected or at a byte boundary.
- R10: irq_o is 1 exactly while the block is enabled and the holding buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Enable bit value |
| ctrl_master_i | input | 1 | 1 = master, 0 = slave |
| ctrl_cpol_i | input | 1 | Clock idle level |
| ctrl_cpha_i | input | 1 | Clock phase select |
| ctrl_lsb_i | input | 1 | 1 = least significant bit first |
| ctrl_div_i | input | DIV_W | Half-period divider value |
| tx_we_i | input | 1 | Holding buffer write strobe |
| tx_data_i | input | DATA_W | Byte to send |
| rx_re_i | input | 1 | Receive register read pulse |
| rx_data_o | output | DATA_W | Last received byte |
| rx_full_o | output | 1 | Unread received byte present |
| tx_empty_o | output | 1 | Holding buffer empty |
| busy_o | output | 1 | Master: shifter active; slave: selected |
| irq_o | output | 1 | Buffer-empty interrupt request |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe_o | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | Serial clock in (slave) |
| ss_ni | input | 1 | Slave select, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data output enable |
| sdi_i | input | 1 | Serial data in |

## Verification
Two collisions are provoked on purpose. In the first, a buffer write lands in the same cycle that the buffer hands its byte to the shifter. The bench issues two writes on consecutive cycles to an idle master, because the first write triggers the hand-off on the very next cycle. It then checks that tx_empty_o stays low and that the wire carries both bytes back to back, with no gap longer than one half period. In the second, a read lands on a completion. The bench holds the read strobe high for a whole transfer and checks that rx_full_o is high for exactly one cycle and not zero.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  typedef struct packed {
    logic master;
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_mode_t;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             cpol_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             tick;

  assign tick    = run_i && (cnt_q == div_i);
  assign lead_o  = tick && !phase_q;
  assign trail_o = tick && phase_q;
  assign sclk_o  = cpol_i ^ phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run_i || restart_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_EDGE_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |=> !lead_o); // R7
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic ss_ni,
  input  logic sdi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic ss_n_o,
  output logic sdi_o
);
  localparam logic [2:0] SYNC_RST = 3'b010; // {sdi, ss_n, sclk}

  logic [2:0] raw;
  logic [2:0] stg [STAGES];
  logic       sclk_prev_q;

  assign raw = {sdi_i, ss_ni, sclk_i};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= SYNC_RST;
      else         stg[g] <= (g == 0) ? raw : stg[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= stg[STAGES-1][0];
  end

  assign sclk_rise_o = stg[STAGES-1][0] && !sclk_prev_q;
  assign sclk_fall_o = !stg[STAGES-1][0] && sclk_prev_q;
  assign ss_n_o      = stg[STAGES-1][1];
  assign sdi_o       = stg[STAGES-1][2];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              cpha_i,
  input  logic              lsb_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q, rx_q, tx_next, rx_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q, out_bit, shift_e, sample_e;

  assign out_bit   = lsb_i ? tx_q[0] : tx_q[DATA_W-1];
  assign tx_next   = lsb_i ? {1'b0, tx_q[DATA_W-1:1]} : {tx_q[DATA_W-2:0], 1'b0};
  assign rx_next   = lsb_i ? {sdi_i, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], sdi_i};
  assign shift_e   = cpha_i ? lead_i : trail_i;
  assign sample_e  = cpha_i ? trail_i : lead_i;
  assign done_o    = trail_i && !clr_i && (cnt_q == CNT_W'(DATA_W-1));
  assign rx_byte_o = cpha_i ? rx_next : rx_q;
  // phase 1 launches on the leading edge, so the bit is held in a flop
  assign sdo_o     = cpha_i ? sdo_q : out_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else if (load_i) begin
      tx_q  <= load_data_i;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      if (shift_e)            tx_q  <= tx_next;
      if (shift_e && cpha_i)  sdo_q <= out_bit;
      if (sample_e)           rx_q  <= rx_next;
      if (done_o)             cnt_q <= '0;
      else if (trail_i)       cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CLR_RESETS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ctrl_en_i,
  input  logic              ctrl_master_i,
  input  logic              ctrl_cpol_i,
  input  logic              ctrl_cpha_i,
  input  logic              ctrl_lsb_i,
  input  logic [DIV_W-1:0]  ctrl_div_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_re_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              tx_empty_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              sclk_i,
  input  logic              ss_ni,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sdi_i
);
  logic              en_q, tx_full_q, mbusy_q, rx_full_q;
  spi_mode_t         mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_buf_q, rx_q, rx_byte;
  logic m_active, s_active, sel, load, clr, done;
  logic m_sclk, m_lead, m_trail;
  logic s_rise, s_fall, s_ss_n, s_sdi;
  logic lead, trail, sdi_mux;

  // control: enable always writable, the rest only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= '0;
      div_q  <= '0;
    end else if (ctrl_we_i) begin
      en_q <= ctrl_en_i;
      if (!en_q) begin
        mode_q <= '{master: ctrl_master_i, cpol: ctrl_cpol_i,
                    cpha: ctrl_cpha_i, lsb_first: ctrl_lsb_i};
        div_q  <= ctrl_div_i;
      end
    end
  end

  assign m_active = en_q && mode_q.master;
  assign s_active = en_q && !mode_q.master;
  assign sel      = s_active && !s_ss_n;
  assign clr      = !en_q || (s_active && s_ss_n);
  assign load     = tx_full_q && (m_active ? (!mbusy_q || done)
                                           : (s_active && (s_ss_n || done)));

  assign lead    = m_active ? m_lead  : (sel && (mode_q.cpol ? s_fall : s_rise));
  assign trail   = m_active ? m_trail : (sel && (mode_q.cpol ? s_rise : s_fall));
  assign sdi_mux = m_active ? sdi_i : s_sdi;

  // holding buffer: a write wins over a same-cycle hand-off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
    end else if (tx_we_i) begin
      tx_buf_q  <= tx_data_i;
      tx_full_q <= 1'b1;
    end else if (load) begin
      tx_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mbusy_q <= 1'b0;
    else if (!m_active) mbusy_q <= 1'b0;
    else if (load)      mbusy_q <= 1'b1;
    else if (done)      mbusy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      rx_full_q <= 1'b0;
    end else if (done) begin
      rx_q      <= rx_byte;
      rx_full_q <= 1'b1;
    end else if (rx_re_i) begin
      rx_full_q <= 1'b0;
    end
  end

  spi_sclk_gen #(.DIV_W(DIV_W)) u_sclk_gen (
    .clk_i, .rst_ni,
    .run_i(mbusy_q), .restart_i(load), .cpol_i(mode_q.cpol), .div_i(div_q),
    .sclk_o(m_sclk), .lead_o(m_lead), .trail_o(m_trail)
  );

  spi_slave_sync #(.STAGES(SYNC_STAGES)) u_slave_sync (
    .clk_i, .rst_ni, .sclk_i, .ss_ni, .sdi_i,
    .sclk_rise_o(s_rise), .sclk_fall_o(s_fall), .ss_n_o(s_ss_n), .sdi_o(s_sdi)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i, .rst_ni, .clr_i(clr), .load_i(load), .load_data_i(tx_buf_q),
    .lead_i(lead), .trail_i(trail), .cpha_i(mode_q.cpha), .lsb_i(mode_q.lsb_first),
    .sdi_i(sdi_mux), .sdo_o, .done_o(done), .rx_byte_o(rx_byte)
  );

  assign rx_data_o  = rx_q;
  assign rx_full_o  = rx_full_q;
  assign tx_empty_o = !tx_full_q;
  assign busy_o     = m_active ? mbusy_q : sel;
  assign irq_o      = en_q && !tx_full_q;
  assign sclk_o     = m_active ? m_sclk : mode_q.cpol;
  assign sclk_oe_o  = m_active;
  assign sdo_oe_o   = m_active || sel;

  AST_TXE_LOW_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_i |=> !tx_empty_o); // R5
  AST_TXE_HIGH_AFTER_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !tx_we_i) |=> tx_empty_o); // R5
  AST_RX_FULL_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rx_full_o); // R8
  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> ($stable(mode_q) && $stable(div_q))); // R2
  AST_NO_GAP_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_active && done && tx_full_q) |=> busy_o); // R6
  AST_SLAVE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_active && s_ss_n) |-> !sdo_oe_o); // R9
endmodule

// File: tb/spi_dbuf_ctrl_tb.sv
module spi_dbuf_ctrl_tb;
  localparam int DW  = 8;
  localparam int DVW = 8;

  typedef struct packed {
    logic          cpol;
    logic          cpha;
    logic          lsb;
    logic [DW-1:0] d;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 1'b0, 8'hA5}, '{1'b0, 1'b1, 1'b0, 8'h3C},
    '{1'b1, 1'b0, 1'b0, 8'h81}, '{1'b1, 1'b1, 1'b0, 8'h4E},
    '{1'b0, 1'b0, 1'b1, 8'h1F}, '{1'b0, 1'b1, 1'b1, 8'hC2},
    '{1'b1, 1'b0, 1'b1, 8'h69}, '{1'b1, 1'b1, 1'b1, 8'h07}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic ctrl_we, ctrl_en, ctrl_master, ctrl_cpol, ctrl_cpha, ctrl_lsb;
  logic [DVW-1:0] ctrl_div;
  logic tx_we, rx_re;
  logic [DW-1:0] tx_data, rx_data;
  logic rx_full, tx_empty, busy, irq, sclk, sclk_oe, sdo, sdo_oe;
  logic sclk_in, ss_n, tb_sdi, tb_slave, sdi;

  assign sdi = tb_slave ? tb_sdi : sdo;

  spi_dbuf_ctrl #(.DATA_W(DW), .DIV_W(DVW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_en_i(ctrl_en), .ctrl_master_i(ctrl_master),
    .ctrl_cpol_i(ctrl_cpol), .ctrl_cpha_i(ctrl_cpha), .ctrl_lsb_i(ctrl_lsb),
    .ctrl_div_i(ctrl_div), .tx_we_i(tx_we), .tx_data_i(tx_data), .rx_re_i(rx_re),
    .rx_data_o(rx_data), .rx_full_o(rx_full), .tx_empty_o(tx_empty), .busy_o(busy),
    .irq_o(irq), .sclk_o(sclk), .sclk_oe_o(sclk_oe), .sclk_i(sclk_in), .ss_ni(ss_n),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sdi_i(sdi)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // wire monitor, samples 2 ns after each rising core clock edge
  logic        mon_prev = 1'b0;
  logic        mon_cpol = 1'b0, mon_cpha = 1'b0;
  int          mon_edges = 0, mon_since = 0, mon_gmin = 1000, mon_gmax = 0;
  logic [15:0] mon_seq = '0;

  always begin
    @(posedge clk); #2;
    if (sclk_oe && (sclk !== mon_prev)) begin
      mon_edges++;
      if (mon_edges > 1) begin
        if (mon_since < mon_gmin) mon_gmin = mon_since;
        if (mon_since > mon_gmax) mon_gmax = mon_since;
      end
      if ((mon_prev == mon_cpol) ^ mon_cpha) mon_seq = {mon_seq[14:0], sdo};
      mon_since = 0;
    end
    mon_since++;
    mon_prev = sclk;
  end

  task automatic mon_clear(input logic cp, input logic ch);
    mon_cpol = cp; mon_cpha = ch; mon_edges = 0; mon_seq = '0;
    mon_gmin = 1000; mon_gmax = 0; mon_since = 0; mon_prev = sclk;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctrl(input logic en, input logic m, input logic cp, input logic ch,
                          input logic l, input logic [DVW-1:0] dv);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_en = en; ctrl_master = m; ctrl_cpol = cp;
    ctrl_cpha = ch; ctrl_lsb = l; ctrl_div = dv;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_tx(input logic [DW-1:0] d);
    @(negedge clk); tx_we = 1'b1; tx_data = d;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic rd_rx();
    @(negedge clk); rx_re = 1'b1;
    @(negedge clk); rx_re = 1'b0;
  endtask

  task automatic wait_rx();
    do @(negedge clk); while (!rx_full);
  endtask

  task automatic wait_edges(input int n, output int busy_low);
    busy_low = 0;
    while (mon_edges < n) begin
      @(negedge clk);
      if (mon_edges < n && !busy) busy_low++;
    end
  endtask

  function automatic logic [DW-1:0] rev(input logic [DW-1:0] d);
    for (int i = 0; i < DW; i++) rev[i] = d[DW-1-i];
  endfunction

  // slave mode 0, most significant bit first
  task automatic slave_xfer(input logic [DW-1:0] b, input int nbits, output logic [DW-1:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      tb_sdi = b[DW-1-i];
      cyc(6);
      got = {got[DW-2:0], sdo};
      sclk_in = 1'b1;
      cyc(6);
      sclk_in = 1'b0;
    end
    cyc(6);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bl;
    int hi;
    logic [DW-1:0] got;
    rst_n = 1'b0; ctrl_we = 0; ctrl_en = 0; ctrl_master = 0; ctrl_cpol = 0;
    ctrl_cpha = 0; ctrl_lsb = 0; ctrl_div = '0; tx_we = 0; tx_data = '0; rx_re = 0;
    sclk_in = 0; ss_n = 1; tb_sdi = 0; tb_slave = 0;
    cyc(4); rst_n = 1'b1; cyc(2);

    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 busy", busy, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 oe", {sclk_oe, sdo_oe}, 0);
    chk("R1 sclk", sclk, 0);
    chk("R10 irq disabled", irq, 0);

    // master: all modes and bit orders, loopback
    for (int i = 0; i < 8; i++) begin
      int dv;
      dv = i % 3;
      set_ctrl(0, 1, VEC[i].cpol, VEC[i].cpha, VEC[i].lsb, DVW'(dv));
      set_ctrl(1, 1, VEC[i].cpol, VEC[i].cpha, VEC[i].lsb, DVW'(dv));
      cyc(1);
      chk("R3 idle level", sclk, VEC[i].cpol);
      chk("R10 irq empty", irq, 1);
      mon_clear(VEC[i].cpol, VEC[i].cpha);
      wr_tx(VEC[i].d);
      wait_rx();
      cyc(1);
      chk("R8 rx byte", rx_data, VEC[i].d);
      chk("R4 wire order", mon_seq[7:0], VEC[i].lsb ? rev(VEC[i].d) : VEC[i].d);
      chk("R3 edge count", mon_edges, 16);
      chk("R7 half period min", mon_gmin, dv + 1);
      chk("R7 half period max", mon_gmax, dv + 1);
      chk("R6 busy end", busy, 0);
      chk("R5 empty after move", tx_empty, 1);
      chk("R3 back to idle", sclk, VEC[i].cpol);
      rd_rx();
      chk("R8 read clears", rx_full, 0);
    end

    // write colliding with buffer-to-shifter move, then chained bytes
    set_ctrl(0, 1, 0, 0, 0, 1);
    set_ctrl(1, 1, 0, 0, 0, 1);
    mon_clear(0, 0);
    @(negedge clk); tx_we = 1'b1; tx_data = 8'hD3;
    @(negedge clk); tx_data = 8'h2B;
    @(negedge clk); tx_we = 1'b0;
    chk("R5 collision keeps byte", tx_empty, 0);
    chk("R10 irq full", irq, 0);
    wait_edges(32, bl);
    cyc(2);
    chk("R6 no busy gap", bl, 0);
    chk("R6 no clock gap", mon_gmax, 2);
    chk("R5 stream", mon_seq, 16'hD32B);
    chk("R8 last byte", rx_data, 8'h2B);
    rd_rx();

    // overwrite of unsent byte
    mon_clear(0, 0);
    wr_tx(8'hE1);
    do @(negedge clk); while (!tx_empty);
    cyc(2); wr_tx(8'h55);
    cyc(2); wr_tx(8'h9A);
    chk("R5 buffer full", tx_empty, 0);
    wait_edges(32, bl);
    cyc(2);
    chk("R5 overwrite stream", mon_seq, 16'hE19A);
    rd_rx();

    // config write while enabled is ignored
    set_ctrl(1, 1, 1, 1, 1, 5);
    cyc(2);
    chk("R2 polarity kept", sclk, 0);
    mon_clear(0, 0);
    wr_tx(8'h96);
    wait_rx(); cyc(1);
    chk("R2 order kept", mon_seq[7:0], 8'h96);
    chk("R2 divider kept", mon_gmax, 2);
    rd_rx();

    // read strobe held across a completion
    mon_clear(0, 0);
    rx_re = 1'b1;
    wr_tx(8'h5A);
    hi = 0;
    while (mon_edges < 16) begin @(negedge clk); if (rx_full) hi++; end
    repeat (4) begin @(negedge clk); if (rx_full) hi++; end
    rx_re = 1'b0;
    chk("R8 set wins over read", hi, 1);
    chk("R8 data", rx_data, 8'h5A);

    // slave mode 0
    set_ctrl(0, 0, 0, 0, 0, 0);
    set_ctrl(1, 0, 0, 0, 0, 0);
    tb_slave = 1'b1;
    cyc(4);
    chk("R9 idle busy", busy, 0);
    chk("R9 idle hiz", sdo_oe, 0);
    wr_tx(8'hA5);
    cyc(2);
    chk("R9 load while deselected", tx_empty, 1);
    ss_n = 1'b0; cyc(4);
    chk("R9 busy follows select", busy, 1);
    chk("R9 drives when selected", sdo_oe, 1);
    slave_xfer(8'h3C, 8, got);
    chk("R9 slave out", got, 8'hA5);
    chk("R8 slave rx full", rx_full, 1);
    chk("R8 slave rx", rx_data, 8'h3C);
    rd_rx();
    ss_n = 1'b1; cyc(4);
    chk("R9 busy released", busy, 0);
    chk("R9 hiz released", sdo_oe, 0);

    // partial byte then deselect
    ss_n = 1'b0; cyc(4);
    slave_xfer(8'hFF, 3, got);
    ss_n = 1'b1; cyc(4);
    chk("R9 hiz after abort", sdo_oe, 0);
    chk("R9 no rx after abort", rx_full, 0);
    ss_n = 1'b0; cyc(4);
    slave_xfer(8'h81, 8, got);
    chk("R9 count restarted", rx_full, 1);
    chk("R9 rx after restart", rx_data, 8'h81);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule